// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a programmed burst mode into the run of column addresses that a DRAM controller presents beat by beat during a read or write burst. The burst mode is a 4-bit code. It is loaded through a write strobe and held in an internal register. The code selects a burst length of 2, 4 or 8 beats, or an open-ended full-page burst. It also selects sequential or interleaved ordering.

A start pulse supplies the first column (8 bits) and the bank (2 bits). From the following cycle the block emits one column per clock with a valid flag. It raises a last flag on the final beat. A full-page burst walks every column of the row, wrapping past the top. It keeps going until a stop request arrives, and it always ends after an even number of beats.

Illegal settings are flagged and emit no addresses. These are a reserved length code, interleaved ordering combined with full page, and a full-page start at an odd column. A new burst may be started during the last beat of the previous one, which gives gap-free bursts.

Top module: `burst_col_gen`

## Requirements
- R1: The mode code bits [2:0] select the burst length: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. Bit 3 selects the order: 0 is sequential, 1 is interleaved. A legal code clears `cfg_err`.
- R2: In sequential order, beat n carries the start column with its low log2(length) bits replaced by (start + n) modulo the length. The upper bits stay at their start value.
- R3: In interleaved order, beat n carries the start column XOR n. n only reaches the low log2(length) bits.
- R4: In full-page mode, beat n carries (start + n) modulo 256 and the burst keeps running. Suppose `stop` is sampled high while beat k is shown. The burst then ends with the first beat whose index is odd and greater than k, so the beat count is always even.
- R5: The full-page code with interleaved order sets `cfg_err`. A start under it pulses `start_err` for one cycle and emits no beats.
- R6: A full-page start at an odd column pulses `start_err` and emits no beats.
- R7: Every reserved length code (000, 100, 101, 110) sets `cfg_err`. A start under it pulses `start_err` and emits no beats.
- R8: Beat 0 appears in the cycle after an accepted start. Beats then follow one per cycle with `beat_valid` high and the bank held, and `beat_last` is high only on the final beat. `stop` has no effect on 2, 4 or 8 beat bursts.
- R9: A start while a burst is running and not on its last beat is ignored, and it raises no `start_err`. A start during the last beat is accepted, and its beat 0 follows with no gap.
- R10: The mode is captured at start. A mode write during a burst does not alter that burst, and it applies to the next one.
- R11: After reset no beat is valid, `start_err` is low, and the mode register holds 4'b0000, so `cfg_err` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_val | input | 4 | Mode code: [3] order, [2:0] length |
| start | input | 1 | Burst start request |
| start_col | input | 8 | First column of the burst |
| start_bank | input | 2 | Bank of the burst |
| stop | input | 1 | Ends a full-page burst |
| beat_valid | output | 1 | A column is presented this cycle |
| beat_col | output | 8 | Column for this beat |
| beat_bank | output | 2 | Bank for this beat |
| beat_last | output | 1 | Final beat of the burst |
| cfg_err | output | 1 | Stored mode code is illegal |
| start_err | output | 1 | One-cycle pulse: the last start was rejected |

## Verification
Two functions can fall in the same cycle: finishing a burst and accepting the next start. The bench raises `start` exactly in the cycle where the last beat is shown. The scoreboard then expects the new burst's beat 0 in the very next cycle, with no gap and no lost or repeated beat.

A full-page stop can also coincide with an even or an odd beat index. Stops are placed on both kinds of index, and the count of emitted beats is judged against the even-length rule. A mid-burst start, stop and mode write all land in one cycle. The running burst must continue unchanged and `start_err` must stay low.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam logic [2:0] LEN_CODE_2  = 3'b001;
  localparam logic [2:0] LEN_CODE_4  = 3'b010;
  localparam logic [2:0] LEN_CODE_8  = 3'b011;
  localparam logic [2:0] LEN_CODE_FP = 3'b111;

  // Decoded burst configuration
  typedef struct packed {
    logic [3:0] lg;   // log2 of the wrap block (column width for full page)
    logic       fp;   // full-page burst
    logic       il;   // interleaved ordering
    logic       bad;  // illegal code
  } bcg_cfg_t;

endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [3:0] mode,
  output bcg_cfg_t   cfg
);

  always_comb begin
    cfg     = '0;
    cfg.il  = mode[3];
    cfg.lg  = 4'd1;
    unique case (mode[2:0])
      LEN_CODE_2:  cfg.lg = 4'd1;
      LEN_CODE_4:  cfg.lg = 4'd2;
      LEN_CODE_8:  cfg.lg = 4'd3;
      LEN_CODE_FP: begin
        cfg.lg = 4'(COL_W);
        cfg.fp = 1'b1;
      end
      default:     cfg.bad = 1'b1;
    endcase
    // full page walks upward only
    if (cfg.fp && cfg.il) cfg.bad = 1'b1;
  end

endmodule

// File: rtl/bcg_seq_ctl.sv
module bcg_seq_ctl
  import bcg_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              stop,
  input  bcg_cfg_t          cfg_in,
  output logic              act,
  output logic              last,
  output logic [COL_W-1:0]  idx,
  output logic [COL_W-1:0]  base,
  output logic [BANK_W-1:0] bank,
  output bcg_cfg_t          cur,
  output logic              rej
);

  logic              act_q, act_d;
  logic [COL_W-1:0]  idx_q, idx_d;
  logic [COL_W-1:0]  base_q, base_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  bcg_cfg_t          cur_q, cur_d;
  logic              pend_q, pend_d;
  logic              rej_q, rej_d;

  logic              slot_free, bad_start, take, give_up, last_c;
  logic [COL_W-1:0]  blk_max;

  always_comb begin
    blk_max   = ~({COL_W{1'b1}} << cur_q.lg);
    last_c    = act_q & (cur_q.fp ? (pend_q & idx_q[0]) : (idx_q == blk_max));
    slot_free = ~act_q | last_c;
    bad_start = cfg_in.bad | (cfg_in.fp & start_col[0]);
    take      = start & slot_free & ~bad_start;
    give_up   = start & slot_free & bad_start;
  end

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    base_d = base_q;
    bank_d = bank_q;
    cur_d  = cur_q;
    pend_d = pend_q;
    rej_d  = give_up;
    if (take) begin
      act_d  = 1'b1;
      idx_d  = '0;
      base_d = start_col;
      bank_d = start_bank;
      cur_d  = cfg_in;
      pend_d = 1'b0;
    end else if (act_q) begin
      if (last_c) begin
        act_d = 1'b0;
      end else begin
        idx_d  = idx_q + 1'b1;
        pend_d = pend_q | (stop & cur_q.fp);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      bank_q <= '0;
      cur_q  <= '0;
      pend_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      bank_q <= bank_d;
      cur_q  <= cur_d;
      pend_q <= pend_d;
      rej_q  <= rej_d;
    end
  end

  assign act  = act_q;
  assign last = last_c;
  assign idx  = idx_q;
  assign base = base_q;
  assign bank = bank_q;
  assign cur  = cur_q;
  assign rej  = rej_q;

  // R5, R6, R7: a rejected start leaves nothing running
  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> !act_q);

  // R8: mid-burst, the beat index advances by one and the bank holds
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last_c) |=> (act_q && idx_q == $past(idx_q) + 1'b1 && $stable(bank_q)));

  // R10: the captured mode cannot change inside a burst
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last_c) |=> $stable(cur_q));

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  bcg_cfg_t         cfg,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] xo;

  assign sum = base + idx;
  assign xo  = base ^ idx;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic in_blk;
    assign in_blk = (b < int'(cfg.lg));
    assign col[b] = in_blk ? (cfg.il ? xo[b] : sum[b]) : base[b];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [3:0]        mode_val,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              stop,
  output logic              beat_valid,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              beat_last,
  output logic              cfg_err,
  output logic              start_err
);

  logic [3:0]       mode_q, mode_d;
  bcg_cfg_t         cfg_live, cfg_cur;
  logic             act, last;
  logic [COL_W-1:0] idx, base;

  always_comb mode_d = mode_wr ? mode_val : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 4'b0000;
    else        mode_q <= mode_d;
  end

  bcg_mode_dec #(.COL_W(COL_W)) u_dec (
    .mode (mode_q),
    .cfg  (cfg_live)
  );

  bcg_seq_ctl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .start_bank (start_bank),
    .stop       (stop),
    .cfg_in     (cfg_live),
    .act        (act),
    .last       (last),
    .idx        (idx),
    .base       (base),
    .bank       (beat_bank),
    .cur        (cfg_cur),
    .rej        (start_err)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .idx  (idx),
    .cfg  (cfg_cur),
    .col  (beat_col)
  );

  assign beat_valid = act;
  assign beat_last  = last;
  assign cfg_err    = cfg_live.bad;

  // R2: bits above the wrap block stay fixed within a fixed-length burst
  p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !cfg_cur.fp) |=>
      ((beat_col >> cfg_cur.lg) == ($past(beat_col) >> cfg_cur.lg)));

  // R4: a full-page burst ends on an odd column (even start, even beat count)
  p_fp_even_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && cfg_cur.fp) |-> beat_col[0]);

  // R8: last flag only with a valid beat
  p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

endmodule

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_wr;
  logic [3:0] mode_val;
  logic       start;
  logic [7:0] start_col;
  logic [1:0] start_bank;
  logic       stop;
  logic       beat_valid, beat_last, cfg_err, start_err;
  logic [7:0] beat_col;
  logic [1:0] beat_bank;

  always #10 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .start(start), .start_col(start_col), .start_bank(start_bank), .stop(stop),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_bank(beat_bank),
    .beat_last(beat_last), .cfg_err(cfg_err), .start_err(start_err)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [10:0] expq[$];
  string       tagq[$];

  int b_lg;
  bit b_il, b_fp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] b, input int i);
    int bl;
    if (b_fp) return 8'(b + i);
    bl = 1 << b_lg;
    if (b_il) return b ^ 8'(i);
    return (b & ~8'(bl - 1)) | (8'(b + i) & 8'(bl - 1));
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && beat_valid === 1'b1) begin
      if (expq.size() == 0) begin
        chk(0, "R8 unexpected beat", {beat_last, beat_bank, beat_col}, 0);
      end else begin
        logic [10:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({beat_last, beat_bank, beat_col} == e, t,
            {beat_last, beat_bank, beat_col}, e);
      end
    end
  end

  task automatic set_mode(input logic [3:0] v);
    bit bad;
    @(negedge clk);
    mode_wr = 1'b1; mode_val = v;
    @(negedge clk);
    mode_wr = 1'b0;
    b_il = v[3];
    b_fp = (v[2:0] == 3'b111);
    bad  = 1'b0;
    case (v[2:0])
      3'b001: b_lg = 1;
      3'b010: b_lg = 2;
      3'b011: b_lg = 3;
      3'b111: b_lg = 8;
      default: bad = 1'b1;
    endcase
    if (b_fp && b_il) bad = 1'b1;
    chk(cfg_err == bad, bad ? "R7/R5 cfg_err set" : "R1 cfg_err clear", cfg_err, bad);
  endtask

  // Returns at the negedge where the last beat is shown
  task automatic burst(input logic [7:0] c, input logic [1:0] bk, input bit disturb,
                       input string tag);
    int bl;
    bl = 1 << b_lg;
    for (int i = 0; i < bl; i++) begin
      expq.push_back({(i == bl - 1), bk, exp_col(c, i)});
      tagq.push_back(tag);
    end
    start = 1'b1; start_col = c; start_bank = bk;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < bl; i++) begin
      if (disturb && i == 3) begin
        start = 1'b1; start_col = 8'h99; stop = 1'b1;
        mode_wr = 1'b1; mode_val = 4'b0001;
      end
      @(negedge clk);
      if (disturb && i == 3) begin
        start = 1'b0; stop = 1'b0; mode_wr = 1'b0;
        chk(start_err == 1'b0, "R9 busy start not rejected", start_err, 0);
      end
    end
  endtask

  task automatic reject(input logic [7:0] c, input string tag);
    @(negedge clk);
    start = 1'b1; start_col = c; start_bank = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk(start_err == 1'b1, tag, start_err, 1);
    chk(beat_valid == 1'b0, tag, beat_valid, 0);
    @(negedge clk);
    chk(start_err == 1'b0, {tag, " pulse"}, start_err, 0);
    chk(beat_valid == 1'b0, tag, beat_valid, 0);
  endtask

  task automatic fp_burst(input logic [7:0] c, input logic [1:0] bk, input int k);
    int l;
    l = (k % 2 == 1) ? k + 2 : k + 1;
    for (int i = 0; i <= l; i++) begin
      expq.push_back({(i == l), bk, 8'(c + i)});
      tagq.push_back("R4 full page");
    end
    @(negedge clk);
    start = 1'b1; start_col = c; start_bank = bk;
    @(negedge clk);
    start = 1'b0;
    repeat (k) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (l - k - 1) @(negedge clk);
    @(negedge clk);
    chk(beat_valid == 1'b0, "R4 ends after last", beat_valid, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_val = '0; start = 1'b0;
    start_col = '0; start_bank = '0; stop = 1'b0;
    b_lg = 1; b_il = 0; b_fp = 0;
    repeat (3) @(negedge clk);
    chk(beat_valid == 1'b0, "R11 no beat in reset", beat_valid, 0);
    chk(cfg_err == 1'b1, "R11 reset mode reserved", cfg_err, 1);
    chk(start_err == 1'b0, "R11 start_err low", start_err, 0);
    rst_n = 1'b1;

    set_mode(4'b0010);
    @(negedge clk);
    burst(8'h35, 2'd2, 0, "R2 seq BL4 wrap");
    // R9: start exactly on the last beat -> no gap
    burst(8'h3E, 2'd1, 0, "R9 back-to-back");
    burst(8'hC7, 2'd0, 0, "R9 back-to-back 2");
    @(negedge clk);

    set_mode(4'b1010);
    @(negedge clk);
    burst(8'h35, 2'd3, 0, "R3 interleave BL4");
    @(negedge clk);
    set_mode(4'b1011);
    @(negedge clk);
    burst(8'h5D, 2'd1, 0, "R3 interleave BL8");
    @(negedge clk);

    set_mode(4'b0011);
    @(negedge clk);
    burst(8'hF3, 2'd2, 1, "R10 R8 disturbed BL8");
    @(negedge clk);
    b_lg = 1; b_il = 0; b_fp = 0;
    chk(cfg_err == 1'b0, "R10 new mode legal", cfg_err, 0);
    burst(8'h81, 2'd0, 0, "R10 next burst BL2");
    @(negedge clk);
    set_mode(4'b1001);
    @(negedge clk);
    burst(8'h07, 2'd1, 0, "R1 interleave BL2");
    @(negedge clk);

    set_mode(4'b1111);
    reject(8'h10, "R5 interleave full page");
    set_mode(4'b0100);
    reject(8'h20, "R7 reserved 100");
    set_mode(4'b0000);
    reject(8'h22, "R7 reserved 000");
    set_mode(4'b1110);
    reject(8'h24, "R7 reserved 110");

    set_mode(4'b0111);
    reject(8'h11, "R6 odd full page start");
    fp_burst(8'hFC, 2'd1, 259);
    fp_burst(8'h20, 2'd3, 4);
    fp_burst(8'h20, 2'd0, 5);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R8 all beats seen", expq.size(), 0);
    chk(beat_valid == 1'b0, "R8 idle at end", beat_valid, 0);
    finish_run();
  end

endmodule